// File: doc/BRIEF.md
# Inbound DMA Address Mode Translator

This block turns a 64-bit address issued by a downstream device into a 54-bit system address. It works out which of five bus windows holds the address, then applies that window's rule. Two windows map directly. The first passes the low bits through. The second joins a per-port base register with a 30-bit offset. The other three windows look up a page entry, and each of these windows has its own page size: 256 KB, 64 MB and 16 GB. These entries sit in two arrays. One array is shared by the 32-bit paged window and the super-page window. The other array serves only the 40-bit paged window.

Each result carries two attributes: an ordering-barrier flag and an interrupt-message flag. It also carries an error flag, which rises when the address lies in no window, when the selected entry is not valid, or when a reserved field is non-zero. The translation runs in a two-stage pipeline. It accepts one address per cycle and returns each result exactly two cycles later. Software fills the entry arrays and the two direct-window base registers through a single-cycle write port.

Top module: `dma_xlate`

## Requirements
- R1: An address with bit 63 set translates to its own bits 53:0. Bit 62 gives the barrier flag and bit 61 gives the message flag. A non-zero value in bits 60:54 gives an error.
- R2: An address in 0x8000_0000..0xFFFF_FFFF maps to {base[in_port], addr[29:0]}. Here the base is the 24-bit field held for that port. The barrier flag equals address bit 30. The message flag is always 0, and no error is raised.
- R3: An address in 0x0..0x7FFF_FFFF uses 256 KB pages. The shared-array index is addr[29:18]. The result is {entry[53:18], addr[17:0]}. The barrier flag is address bit 30, and the message flag is entry bit 62. An index below 64, or at or above SHARED_DEPTH, gives an error.
- R4: An address in 0x40_0000_0000..0x7F_FFFF_FFFF uses 64 MB pages from the separate wide array. The index is addr[37:26] and the result is {entry[53:26], addr[25:0]}. Both flags are 0, whatever the entry's bit 62. An index at or above WIDE_DEPTH gives an error.
- R5: An address in 0x80_0000_0000..0xFF_FFFF_FFFF uses 16 GB pages. The shared-array index is in_port*32 + addr[38:34]. The result is {entry[53:34], addr[33:0]}, and both flags are 0.
- R6: A paged lookup whose entry has bit 63 clear gives an error.
- R7: An address that lies in none of the five windows gives an error. Examples are 0x1_0000_0000..0x3F_FFFF_FFFF, and any address with bit 63 clear and a bit from 40 to 62 set.
- R8: While out_err is high, out_addr, out_barrier and out_msi are all 0.
- R9: A request taken with in_valid high gives out_valid high exactly two cycles later. Back-to-back requests give back-to-back results in order.
- R10: After reset, out_valid is 0, every entry is invalid and both direct bases are 0.
- R11: A write with wr_en high acts as follows, chosen by wr_sel. Code 0 writes shared entry wr_idx. Code 1 writes wide entry wr_idx. Code 2 loads wr_data[53:30] into the base of port wr_idx[0]. Code 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_addr | input | 64 | Inbound bus address |
| in_port | input | 1 | Requesting port, 0 or 1 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 shared, 1 wide, 2 base, 3 none |
| wr_idx | input | 12 | Entry index, or port number in bit 0 |
| wr_data | input | 64 | Write data |
| out_valid | output | 1 | Result present |
| out_addr | output | 54 | Translated system address |
| out_barrier | output | 1 | Ordering-barrier attribute |
| out_msi | output | 1 | Interrupt-message attribute |
| out_err | output | 1 | Translation failed |

## Verification
A corrupted entry, base register or mode decode shows up at the ports two cycles after the affected request. It appears as a wrong high-order address field, a wrong flag, or a wrong error bit, while the low offset bits stay correct. Each window is therefore tested with an offset pattern and an entry pattern that do not overlap, so a wrong page-size split is visible at once. A lost or extra pipeline stage shows as out_valid rising one cycle early or late during a back-to-back burst.

// File: rtl/dma_xlate.sv
module dma_xlate #(
  parameter int SHARED_DEPTH = 128,
  parameter int WIDE_DEPTH   = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_addr,
  input  logic        in_port,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [11:0] wr_idx,
  input  logic [63:0] wr_data,
  output logic        out_valid,
  output logic [53:0] out_addr,
  output logic        out_barrier,
  output logic        out_msi,
  output logic        out_err
);
  localparam int SYS_W = 54;
  localparam int SUPER_PER_PORT = 32;
  localparam int RSVD = 2 * SUPER_PER_PORT;
  localparam int SH_AW = $clog2(SHARED_DEPTH);
  localparam int WD_AW = $clog2(WIDE_DEPTH);
  localparam logic [11:0] SH_LIM = 12'(SHARED_DEPTH);
  localparam logic [11:0] WD_LIM = 12'(WIDE_DEPTH);
  localparam logic [11:0] RS_LIM = 12'(RSVD);

  typedef enum logic [2:0] {M_NONE, M_D64, M_D32, M_M32, M_M40, M_SUP} mode_t;

  logic [63:0] shared_mem [SHARED_DEPTH];
  logic [63:0] wide_mem   [WIDE_DEPTH];
  logic [23:0] dir_base   [2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SHARED_DEPTH; i++) shared_mem[i] <= '0;
      for (int i = 0; i < WIDE_DEPTH; i++) wide_mem[i] <= '0;
      dir_base[0] <= '0;
      dir_base[1] <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: if (wr_idx < SH_LIM) shared_mem[wr_idx[SH_AW-1:0]] <= wr_data;
        2'd1: if (wr_idx < WD_LIM) wide_mem[wr_idx[WD_AW-1:0]] <= wr_data;
        2'd2: dir_base[wr_idx[0]] <= wr_data[53:30];
        default: ;
      endcase
    end
  end

  mode_t mode;
  always_comb begin
    if (in_addr[63])                                  mode = M_D64;
    else if (in_addr[62:32] == '0 && in_addr[31])     mode = M_D32;
    else if (in_addr[62:31] == '0)                    mode = M_M32;
    else if (in_addr[62:39] == '0 && in_addr[38])     mode = M_M40;
    else if (in_addr[62:40] == '0 && in_addr[39])     mode = M_SUP;
    else                                              mode = M_NONE;
  end

  wire [11:0] m32_idx = in_addr[29:18];
  wire [11:0] m40_idx = in_addr[37:26];
  wire [11:0] sup_idx = {6'd0, in_port, in_addr[38:34]};
  wire [11:0] sh_idx  = (mode == M_SUP) ? sup_idx : m32_idx;
  wire        sh_in   = sh_idx < SH_LIM;
  wire        wd_in   = m40_idx < WD_LIM;

  wire [63:0] sh_ent  = sh_in ? shared_mem[sh_idx[SH_AW-1:0]] : 64'd0;
  wire [63:0] wd_ent  = wd_in ? wide_mem[m40_idx[WD_AW-1:0]] : 64'd0;

  logic [63:0] pick_ent;
  logic        range_ok;
  always_comb begin
    pick_ent = '0;
    range_ok = 1'b1;
    case (mode)
      M_D32: pick_ent = {10'd0, dir_base[in_port], 30'd0};
      M_M32: begin pick_ent = sh_ent; range_ok = sh_in && (m32_idx >= RS_LIM); end
      M_M40: begin pick_ent = wd_ent; range_ok = wd_in; end
      M_SUP: pick_ent = sh_ent;
      default: ;
    endcase
  end

  logic        s1_v;
  mode_t       s1_mode;
  logic [63:0] s1_addr;
  logic [63:0] s1_ent;
  logic        s1_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_mode <= M_NONE;
      s1_addr <= '0;
      s1_ent  <= '0;
      s1_ok   <= 1'b0;
    end else begin
      s1_v    <= in_valid;
      s1_mode <= mode;
      s1_addr <= in_addr;
      s1_ent  <= pick_ent;
      s1_ok   <= range_ok;
    end
  end

  logic [SYS_W-1:0] x_addr;
  logic             x_bar, x_msi, x_err;
  always_comb begin
    x_addr = '0;
    x_bar  = 1'b0;
    x_msi  = 1'b0;
    x_err  = 1'b0;
    case (s1_mode)
      M_D64: begin
        x_addr = s1_addr[53:0];
        x_bar  = s1_addr[62];
        x_msi  = s1_addr[61];
        x_err  = |s1_addr[60:54];
      end
      M_D32: begin
        x_addr = {s1_ent[53:30], s1_addr[29:0]};
        x_bar  = s1_addr[30];
      end
      M_M32: begin
        x_addr = {s1_ent[53:18], s1_addr[17:0]};
        x_bar  = s1_addr[30];
        x_msi  = s1_ent[62];
        x_err  = !s1_ok || !s1_ent[63];
      end
      M_M40: begin
        x_addr = {s1_ent[53:26], s1_addr[25:0]};
        x_err  = !s1_ok || !s1_ent[63];
      end
      M_SUP: begin
        x_addr = {s1_ent[53:34], s1_addr[33:0]};
        x_err  = !s1_ent[63];
      end
      default: x_err = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_addr    <= '0;
      out_barrier <= 1'b0;
      out_msi     <= 1'b0;
      out_err     <= 1'b0;
    end else begin
      out_valid   <= s1_v;
      out_err     <= s1_v && x_err;
      out_addr    <= (s1_v && !x_err) ? x_addr : '0;
      out_barrier <= s1_v && !x_err && x_bar;
      out_msi     <= s1_v && !x_err && x_msi;
    end
  end
endmodule

// File: rtl/dma_xlate_chk.sv
module dma_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] in_addr,
  input logic        out_valid,
  input logic [53:0] out_addr,
  input logic        out_barrier,
  input logic        out_msi,
  input logic        out_err
);
  logic [1:0] vq;
  always_ff @(posedge clk) begin
    if (!rst_n) vq <= '0;
    else        vq <= {vq[0], in_valid};
  end

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vq[1]);

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_addr == '0 && !out_barrier && !out_msi));

  assert_d64_rsvd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_addr[63] && |in_addr[60:54]) |=> ##1 out_err);

  assert_d32_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_addr[63:31] == 33'h1) |=> ##1
      (!out_msi && !out_err && out_barrier == $past(in_addr[30], 2)));

  assert_wide_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_addr[63:39] == '0 && in_addr[38]) |=> ##1 (!out_barrier && !out_msi));

  assert_super_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_addr[63:40] == '0 && in_addr[39]) |=> ##1 (!out_barrier && !out_msi));

  assert_hole_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_addr[63:38] == '0 && in_addr[37:32] != '0) |=> ##1 out_err);
endmodule

bind dma_xlate dma_xlate_chk u_chk (.*);

// File: tb/dma_xlate_tb.sv
module dma_xlate_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [63:0] in_addr = '0;
  logic        in_port = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_sel = '0;
  logic [11:0] wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        out_valid;
  logic [53:0] out_addr;
  logic        out_barrier, out_msi, out_err;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_xlate u_dut (.*);

  task automatic chk(string req, logic e_err, logic [53:0] e_addr, logic e_bar, logic e_msi);
    checks++;
    if (out_valid !== 1'b1 || out_err !== e_err || out_addr !== e_addr ||
        out_barrier !== e_bar || out_msi !== e_msi) begin
      fails++;
      $display("FAIL %s: got v=%b err=%b addr=%h bar=%b msi=%b, expected v=1 err=%b addr=%h bar=%b msi=%b",
               req, out_valid, out_err, out_addr, out_barrier, out_msi, e_err, e_addr, e_bar, e_msi);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [11:0] idx, logic [63:0] data);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_idx = idx; wr_data = data;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic xl(logic [63:0] a, logic p, string req,
                    logic e_err, logic [53:0] e_addr, logic e_bar, logic e_msi);
    @(negedge clk);
    in_valid = 1; in_addr = a; in_port = p;
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    chk(req, e_err, e_addr, e_bar, e_msi);
  endtask

  task automatic t_reset;
    checks++;
    if (out_valid !== 1'b0 || out_err !== 1'b0) begin
      fails++;
      $display("FAIL R10: got v=%b err=%b, expected v=0 err=0", out_valid, out_err);
    end
    xl(64'h0000_0000_8000_0005, 0, "R10 base zero", 0, 54'h5, 0, 0);
    xl(64'h0000_0000_0190_0000, 0, "R10 entry invalid", 1, 54'h0, 0, 0);
  endtask

  task automatic t_d64;
    xl(64'hC012_3456_789A_BCDE, 0, "R1 barrier", 0, 54'h12_3456_789A_BCDE, 1, 0);
    xl(64'hA000_0000_0000_1000, 1, "R1 msi", 0, 54'h1000, 0, 1);
    xl(64'h8040_0000_0000_0000, 0, "R1 reserved", 1, 54'h0, 0, 0);
  endtask

  task automatic t_d32;
    wr(2'd2, 12'd0, 64'h0000_0ABC_C000_0000);
    wr(2'd2, 12'd1, 64'h0000_0001_4000_0000);
    xl(64'h0000_0000_C123_4567, 0, "R2 port0", 0, 54'h0ABC_C123_4567, 1, 0);
    xl(64'h0000_0000_8000_0010, 1, "R2 port1", 0, 54'h1_4000_0010, 0, 0);
  endtask

  task automatic t_m32;
    wr(2'd0, 12'd70, 64'hC000_0000_0ABC_0000);
    xl(64'h0000_0000_4118_1234, 0, "R3 hit", 0, 54'h0ABC_1234, 1, 1);
    xl(64'h0000_0000_00FC_0000, 0, "R3 reserved index", 1, 54'h0, 0, 0);
    xl(64'h0000_0000_0320_0000, 0, "R3 past depth", 1, 54'h0, 0, 0);
    xl(64'h0000_0000_0190_0000, 0, "R6 invalid entry", 1, 54'h0, 0, 0);
  endtask

  task automatic t_m40;
    wr(2'd1, 12'd5, 64'hC000_0001_2800_0000);
    xl(64'h0000_0040_1523_4567, 0, "R4 hit", 0, 54'h1_2923_4567, 0, 0);
    xl(64'h0000_0041_0000_0000, 0, "R4 past depth", 1, 54'h0, 0, 0);
  endtask

  task automatic t_super;
    wr(2'd0, 12'd35, 64'h8000_0048_0000_0000);
    xl(64'h0000_008D_4345_6789, 1, "R5 port1", 0, 54'h49_4345_6789, 0, 0);
    xl(64'h0000_008D_4345_6789, 0, "R5 port0 separate", 1, 54'h0, 0, 0);
  endtask

  task automatic t_holes;
    xl(64'h0000_0002_0000_0000, 0, "R7 gap", 1, 54'h0, 0, 0);
    xl(64'h0100_0000_0000_0000, 0, "R7 high", 1, 54'h0, 0, 0);
  endtask

  task automatic t_write_none;
    wr(2'd3, 12'd100, 64'h8000_0000_0000_0000);
    xl(64'h0000_0000_0190_0000, 0, "R11 code3", 1, 54'h0, 0, 0);
  endtask

  task automatic t_stream;
    @(negedge clk);
    in_valid = 1; in_addr = 64'h8000_0000_0000_0011;
    @(negedge clk);
    in_addr = 64'h8000_0000_0000_0022;
    @(negedge clk);
    in_addr = 64'h8000_0000_0000_0033;
    chk("R9 first", 0, 54'h11, 0, 0);
    @(negedge clk);
    in_valid = 0;
    chk("R9 second", 0, 54'h22, 0, 0);
    @(negedge clk);
    chk("R9 third", 0, 54'h33, 0, 0);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R9 drain: got v=%b, expected v=0", out_valid);
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_d64();
    t_d32();
    t_m32();
    t_m40();
    t_super();
    t_holes();
    t_write_none();
    t_stream();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hang, expected completion");
      finish_run();
    end
  end
endmodule